// File: doc/BRIEF.md
# Banked Host Register Interface

This block connects an 8-bit asynchronous host bus to a file of nineteen byte-wide registers that are seen through sixteen consecutive addresses. The bus strobes (select, read, write, address latch) are brought into the core clock domain through a synchronizer. A write lands when the write strobe returns high. A read drives the selected register onto the read data port for as long as the strobe stays active.

The address comes from one of two places. On a multiplexed bus, the low four lines of the shared address/data bus are captured while the address latch enable is high, and line 6 is captured into a separate mode flag. On a bus with separate address lines, the latch enable is tied high and the address lines pass straight through. Bit 4 of register 0 selects the bank. While it is set, addresses 11, 12 and 13 reach three alternate registers instead of the foreground ones. Address 0 is never redirected, so the bank can always be switched back.

For every qualified read, the block gives a one-cycle pulse and the physical register index, so neighbouring logic can apply clear-on-read effects. All pins are plain control and data pins. There is no handshake: the host keeps the address and data stable across the synchronizer delay.

Top module: `hostbus_regbank`

## Requirements
- R1: After reset every register reads 0, `alt_sel` and `mode_flag` are 0, and `rd_pulse` and `drive_en` are low.
- R2: A write strobe (`wr_n` low, then high) with `cs_n` low stores the `ad_in` byte into the addressed register, and a later read returns that byte.
- R3: While bit 4 of register 0 is 1, addresses 11, 12 and 13 reach alternate registers with physical indices 16, 17 and 18. The foreground registers 11 to 13 are left unchanged.
- R4: While bit 4 of register 0 is 0, addresses 11 to 13 reach foreground registers 11 to 13, and the alternate registers keep their contents.
- R5: Address 0 always reaches physical register 0 in either bank, so writing 0 to bit 4 returns to the foreground bank; `alt_sel` mirrors bit 4.
- R6: When `bus_mux` = 1, the address is taken from `ad_in[3:0]` while `ale` is high and held while `ale` is low. `ad_in[6]` is captured at the same time into `mode_flag`.
- R7: When `bus_mux` = 0 and `ale` is held high, the address follows `addr_in` and `mode_flag` reads 0.
- R8: A read or write strobe while `cs_n` is high stores nothing, gives no `rd_pulse` and leaves `drive_en` low.
- R9: Each qualified read strobe gives exactly one one-cycle `rd_pulse`. While the pulse is high, `rd_index` carries the physical index: the address for the foreground, or 16 + (address − 11) for an alternate.
- R10: While `cs_n` and `rd_n` are both low (after synchronization), `drive_en` is high and `rd_data` holds the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mux | input | 1 | 1 = multiplexed address/data bus, 0 = separate address lines |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| ale | input | 1 | Address latch enable; tie high for separate address lines |
| addr_in | input | 4 | Separate address lines |
| ad_in | input | 8 | Data bus, also carries the address in multiplexed mode |
| rd_data | output | 8 | Selected register contents |
| drive_en | output | 1 | High while a qualified read is active |
| rd_pulse | output | 1 | One-cycle pulse per qualified read |
| rd_index | output | 5 | Physical register index of the current access |
| alt_sel | output | 1 | Current alternate-bank select bit |
| mode_flag | output | 1 | Latched `ad_in[6]` from the multiplexed address phase |

## Verification
The bench sweeps all sixteen addresses three times, each time with address-dependent values computed in the bench. The first pass uses separate lines and the foreground bank. The second uses the multiplexed bus with the alternate bank. The third returns to the foreground bank. Comparing the passes shows whether addresses 11 to 13 switch to the alternates while every other address, register 0 included, stays put. Strobes with the select high show whether the select really gates accesses. A read with a different address on the bus and the latch enable low shows whether the latched address is held. The mode flag is tested with line 6 set and then clear.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Strobe bundle carried through the synchronizer as one vector.
  typedef struct packed {
    logic ale;
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  // Idle levels of the strobes: latch closed, select and strobes inactive.
  localparam strobe_t STROBE_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic              bus_mux,
  input  logic [ADDR_W-1:0] mux_addr,
  input  logic              mux_flag,
  input  logic [ADDR_W-1:0] sep_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              flag_q
);

  logic [ADDR_W-1:0] addr_src;

  assign addr_src = bus_mux ? mux_addr : sep_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      flag_q <= 1'b0;
    end else if (ale_s) begin
      addr_q <= addr_src;
      flag_q <= bus_mux & mux_flag;
    end
  end

  // R6: with the latch closed the captured address stays put
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_s |=> $stable(addr_q));

  // R7: the flag is only ever taken from a multiplexed address phase
  a_r7_flag_sep: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_s && !bus_mux) |=> !flag_q);

endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int ADDR_W    = 4,
  parameter int ALT_FIRST = 11,
  parameter int ALT_COUNT = 3,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] log_addr,
  input  logic              alt,
  output logic [IDX_W-1:0]  phys_idx
);

  localparam int ALT_BASE = 2 ** ADDR_W;

  if (ALT_COUNT == 0) begin : g_flat
    logic unused_alt;
    assign unused_alt = alt;
    assign phys_idx   = IDX_W'(log_addr);
  end else begin : g_banked
    logic in_win;
    assign in_win   = (int'(log_addr) >= ALT_FIRST) &&
                      (int'(log_addr) <  ALT_FIRST + ALT_COUNT);
    assign phys_idx = (alt && in_win)
                    ? IDX_W'(ALT_BASE + int'(log_addr) - ALT_FIRST)
                    : IDX_W'(log_addr);
  end

endmodule

// File: rtl/reg_file.sv
module reg_file #(
  parameter int DATA_W  = 8,
  parameter int NREG    = 19,
  parameter int IDX_W   = 5,
  parameter int ALT_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              alt_bit
);

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_idx == IDX_W'(i)) regs[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
    end
  end

  assign alt_bit = regs[0][ALT_BIT];

  // R2: a committed byte is what the same index reads next cycle
  a_r2_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> (rd_data == $past(wr_data) || rd_idx != $past(wr_idx)));

endmodule

// File: rtl/hostbus_regbank.sv
module hostbus_regbank #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ALT_FIRST   = 11,
  parameter int ALT_COUNT   = 3,
  parameter int ALT_BIT     = 4,
  parameter int FLAG_LINE   = 6,
  parameter int IDX_W       = $clog2(2 ** ADDR_W + ALT_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mux,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              drive_en,
  output logic              rd_pulse,
  output logic [IDX_W-1:0]  rd_index,
  output logic              alt_sel,
  output logic              mode_flag
);

  import regbank_pkg::*;

  localparam int NREG = 2 ** ADDR_W + ALT_COUNT;

  strobe_t          strb_raw, strb_s;
  logic             rd_n_d, wr_n_d;
  logic             cs_act, rd_act;
  logic             wr_seen_q, wr_commit;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  phys_idx;

  assign strb_raw = '{ale: ale, cs_n: cs_n, rd_n: rd_n, wr_n: wr_n};

  bus_sync #(
    .WIDTH  (STROBE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STROBE_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (strb_raw),
    .q    (strb_s)
  );

  addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_s   (strb_s.ale),
    .bus_mux (bus_mux),
    .mux_addr(ad_in[ADDR_W-1:0]),
    .mux_flag(ad_in[FLAG_LINE]),
    .sep_addr(addr_in),
    .addr_q  (addr_q),
    .flag_q  (mode_flag)
  );

  bank_decode #(
    .ADDR_W   (ADDR_W),
    .ALT_FIRST(ALT_FIRST),
    .ALT_COUNT(ALT_COUNT),
    .IDX_W    (IDX_W)
  ) u_decode (
    .log_addr(addr_q),
    .alt     (alt_sel),
    .phys_idx(phys_idx)
  );

  // Strobe edge history and write data capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n_d    <= 1'b1;
      wr_n_d    <= 1'b1;
      wr_seen_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      rd_n_d    <= strb_s.rd_n;
      wr_n_d    <= strb_s.wr_n;
      wr_seen_q <= cs_act && !strb_s.wr_n;
      if (cs_act && !strb_s.wr_n) wdata_q <= ad_in;
    end
  end

  assign cs_act    = !strb_s.cs_n;
  assign rd_act    = cs_act && !strb_s.rd_n;
  assign wr_commit = strb_s.wr_n && !wr_n_d && wr_seen_q;
  assign rd_pulse  = rd_act && rd_n_d;
  assign drive_en  = rd_act;
  assign rd_index  = phys_idx;

  reg_file #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .IDX_W  (IDX_W),
    .ALT_BIT(ALT_BIT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_commit),
    .wr_idx (phys_idx),
    .wr_data(wdata_q),
    .rd_idx (phys_idx),
    .rd_data(rd_data),
    .alt_bit(alt_sel)
  );

  // R9: a read pulse never lasts more than one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse);

  // R8/R10: a read pulse only occurs inside an output-enabled read
  a_r8_pulse_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |-> drive_en);

  // R5: address 0 is never redirected
  a_r5_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == '0) |-> (rd_index == '0));

  // R3: an index past the foreground range needs the alternate bank
  a_r3_alt_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_index) >= 2 ** ADDR_W) |-> alt_sel);

  // R4: with the bank bit clear the index equals the address
  a_r4_fg_identity: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_sel |-> (rd_index == IDX_W'(addr_q)));

endmodule

// File: tb/hostbus_regbank_tb.sv
`timescale 1ns/1ps
module hostbus_regbank_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_mux = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b1;
  logic [3:0] addr_in = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] rd_data;
  logic       drive_en, rd_pulse, alt_sel, mode_flag;
  logic [4:0] rd_index;

  int n_chk = 0, n_fail = 0;
  int pulse_cnt = 0;
  int last_idx = -1;
  logic [7:0] mdl [19];
  bit mdl_alt = 0;

  always #10 clk = ~clk;

  hostbus_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mux(bus_mux), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ale(ale), .addr_in(addr_in), .ad_in(ad_in),
    .rd_data(rd_data), .drive_en(drive_en), .rd_pulse(rd_pulse),
    .rd_index(rd_index), .alt_sel(alt_sel), .mode_flag(mode_flag)
  );

  always @(negedge clk) begin
    if (rd_pulse) begin
      pulse_cnt++;
      last_idx = int'(rd_index);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int phys_of(input int a, input bit alt);
    return (alt && a >= 11 && a <= 13) ? 16 + a - 11 : a;
  endfunction

  task automatic set_addr(input bit mux, input int a, input bit flag);
    if (mux) begin
      bus_mux = 1'b1;
      ad_in   = {1'b0, flag, 2'b00, 4'(a)};
      ale     = 1'b1;
      repeat (5) @(negedge clk);
      ale = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      bus_mux = 1'b0;
      ale     = 1'b1;
      addr_in = 4'(a);
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic bus_write(input bit mux, input int a, input logic [7:0] d, input bit sel);
    set_addr(mux, a, 1'b0);
    ad_in = d;
    cs_n  = !sel;
    wr_n  = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    if (sel) begin
      mdl[phys_of(a, mdl_alt)] = d;
      if (a == 0) mdl_alt = d[4];
    end
  endtask

  task automatic bus_read(input bit mux, input int a, input bit sel,
                          output logic [7:0] d, output logic de, output int np);
    int p0;
    set_addr(mux, a, 1'b0);
    p0   = pulse_cnt;
    cs_n = !sel;
    rd_n = 1'b0;
    repeat (6) @(negedge clk);
    d  = rd_data;
    de = drive_en;
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    np = pulse_cnt - p0;
  endtask

  task automatic read_check(input bit mux, input int a, input string req);
    logic [7:0] d; logic de; int np;
    bus_read(mux, a, 1'b1, d, de, np);
    chk({req, " data"}, int'(d), int'(mdl[phys_of(a, mdl_alt)]));
    chk("R10 drive_en", int'(de), 1);
    chk("R9 pulse count", np, 1);
    chk("R9 rd_index", last_idx, phys_of(a, mdl_alt));
  endtask

  initial begin
    logic [7:0] d; logic de; int np;
    for (int i = 0; i < 19; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 drive_en", int'(drive_en), 0);
    chk("R1 rd_pulse", int'(rd_pulse), 0);
    chk("R1 alt_sel", int'(alt_sel), 0);
    chk("R1 mode_flag", int'(mode_flag), 0);
    for (int a = 0; a < 16; a++) read_check(1'b0, a, "R1 reset value");

    // R2 / R7: separate-line writes across the whole map
    bus_write(1'b0, 0, 8'hA5, 1'b1);
    for (int a = 1; a < 16; a++) bus_write(1'b0, a, 8'((a * 37 + 11) & 255), 1'b1);
    for (int a = 0; a < 16; a++) read_check(1'b0, a, "R2 R7 sep");
    chk("R7 mode_flag sep", int'(mode_flag), 0);

    // R3 / R6: enable the alternate bank over the multiplexed bus
    bus_write(1'b1, 0, 8'hB5, 1'b1);
    chk("R5 alt_sel set", int'(alt_sel), 1);
    for (int a = 11; a < 14; a++) bus_write(1'b1, a, 8'h5A ^ 8'(a), 1'b1);
    for (int a = 0; a < 16; a++) read_check(1'b1, a, "R3 R6 alt mux");

    // R6: address line 6 goes into the mode flag
    set_addr(1'b1, 2, 1'b1);
    chk("R6 mode_flag set", int'(mode_flag), 1);
    set_addr(1'b1, 2, 1'b0);
    chk("R6 mode_flag clear", int'(mode_flag), 0);

    // R5 / R4: address 0 still reaches register 0; back to the foreground
    bus_write(1'b1, 0, 8'hA5, 1'b1);
    chk("R5 alt_sel clear", int'(alt_sel), 0);
    for (int a = 0; a < 16; a++) read_check(1'b0, a, "R4 fg sep");
    bus_write(1'b0, 0, 8'h10, 1'b1);
    for (int a = 11; a < 14; a++) read_check(1'b0, a, "R4 alt retained");
    read_check(1'b1, 0, "R5 reg0 in alt bank");
    bus_write(1'b0, 0, 8'h00, 1'b1);

    // R8: strobes with select high
    bus_write(1'b0, 5, 8'hEE, 1'b0);
    bus_read(1'b0, 5, 1'b0, d, de, np);
    chk("R8 drive_en", int'(de), 0);
    chk("R8 no pulse", np, 0);
    read_check(1'b0, 5, "R8 no write");

    // R6: latched address held while the bus shows another address
    set_addr(1'b1, 7, 1'b0);
    ad_in = 8'h03;
    repeat (4) @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 held address", int'(rd_data), int'(mdl[7]));
    chk("R6 held index", int'(rd_index), 7);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule